// File: doc/BRIEF.md
# Fractional Tick Divider

This block turns one of two incoming source tick streams into a slower module clock enable. The divisor is an integer part N plus a fraction a/b. Each output period lasts either N or N+1 source ticks. The choice comes from an error accumulator, so the longer periods are spread evenly and the mean period over many periods is N + a/b. The block does not create a new clock domain. Its output is a single-cycle enable pulse, `mod_tick`, in the system clock domain.

Both sources arrive as enable ticks. A select setting picks between them: one is the crystal tick and the other is the internal 8 MHz tick. A run input gates the divider off; while it is gated, `gated_off` is asserted. Divider settings are sampled only when a period ends, so changing them never produces a shortened period.

Top module: `frac_tick_div`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mod_tick` is 0 and `gated_off` is 0. The run state resets to running. The divider state resets to a startup period of length one, and the stored source select resets to 0.
- R2: A stored select of 0 counts only `xtal_tick` cycles and a stored select of 1 counts only `rc_tick` cycles. Ticks on the unselected source have no effect on the period or on `mod_tick`.
- R3: When 0 < a < b, an accumulator adds a at every period end. A period whose sum reaches b lasts N+1 selected ticks and keeps sum−b; otherwise the period lasts N ticks and keeps the sum. Over any b consecutive periods of a constant setting, exactly a periods are stretched.
- R4: When a = 0 or b = 0, every period lasts exactly N selected ticks.
- R5: An integer part of 0 divides by 1.
- R6: When b ≠ 0 and a ≥ b, every period lasts N+1 selected ticks.
- R7: `src_sel`, `div_int`, `frac_num` and `frac_den` are sampled only at the selected tick that ends a period; changes inside a period do not alter that period. When the sampled settings differ from the previous ones, the accumulator restarts from 0.
- R8: When `run_en` is low at a clock edge, `gated_off` is 1 after that edge. While gated, no `mod_tick` occurs and the divider returns to the startup state. The selected tick after the run state resumes ends the startup period.
- R9: `mod_tick` is high for exactly the one clock cycle after the edge at which the period-ending selected tick was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | 1 lets the divider run, 0 gates it off |
| src_sel | input | 1 | Source choice: 0 crystal tick, 1 internal 8 MHz tick |
| div_int | input | 8 | Integer part N of the divisor |
| frac_num | input | 6 | Fraction numerator a |
| frac_den | input | 6 | Fraction denominator b |
| xtal_tick | input | 1 | Crystal source tick |
| rc_tick | input | 1 | Internal 8 MHz source tick |
| mod_tick | output | 1 | Single-cycle module clock enable |
| gated_off | output | 1 | High while the divider is gated off |

## Verification
Constant, always-present ticks with a pure integer, a zero integer, a true fraction and an over-unity fraction give tick counts over windows that are whole multiples of the pattern length. These counts separate N, N+1 and the a-of-b stretching rule. Silencing the selected source while the other keeps ticking shows whether the wrong source leaks through. Switching the select in mid-period shows whether settings are taken only at a period end. A divide-by-20 period cut short by a new setting tells a boundary-only update from an immediate one. Random settings, random tick densities and random gating are compared cycle by cycle against a bench model, which exposes off-by-one period lengths, accumulator carry errors and ticks leaking through while gated.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    parameter int INT_W = 8;
    parameter int FRAC_W = 6;
    parameter int SRC_N = 2;
    localparam int LEN_W = INT_W + 1;
    localparam int ACC_W = FRAC_W + 1;
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1;

    typedef struct packed {
        logic [SEL_W-1:0]  src_sel;
        logic [INT_W-1:0]  div_int;
        logic [FRAC_W-1:0] num;
        logic [FRAC_W-1:0] den;
    } fdiv_cfg_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [ACC_W-1:0] acc;
    } fdiv_step_t;
endpackage

// File: rtl/fdiv_src_mux.sv
module fdiv_src_mux
    import fdiv_pkg::*;
(
    input  logic [SRC_N-1:0] src_ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (sel == SEL_W'(i)) begin
                tick = src_ticks[i];
            end
        end
    end
endmodule

// File: rtl/fdiv_frac_step.sv
module fdiv_frac_step
    import fdiv_pkg::*;
(
    input  fdiv_cfg_t        cur_cfg,
    input  fdiv_cfg_t        new_cfg,
    input  logic [ACC_W-1:0] acc_in,
    output fdiv_step_t       nxt
);
    logic [LEN_W-1:0] n_eff;
    logic [ACC_W-1:0] num_w;
    logic [ACC_W-1:0] den_w;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;
    logic             frac_on;
    logic             full_on;

    always_comb begin
        n_eff   = (new_cfg.div_int == '0) ? LEN_W'(1) : LEN_W'(new_cfg.div_int);
        num_w   = ACC_W'(new_cfg.num);
        den_w   = ACC_W'(new_cfg.den);
        base    = (new_cfg == cur_cfg) ? acc_in : '0;
        sum     = base + num_w;
        frac_on = (num_w != '0) && (den_w != '0) && (num_w < den_w);
        full_on = (num_w != '0) && (den_w != '0) && !frac_on;
        nxt.len = n_eff;
        nxt.acc = '0;
        if (frac_on) begin
            if (sum >= den_w) begin
                nxt.len = n_eff + LEN_W'(1);
                nxt.acc = sum - den_w;
            end else begin
                nxt.acc = sum;
            end
        end else if (full_on) begin
            nxt.len = n_eff + LEN_W'(1);
        end
    end
endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             src_tick,
    input  fdiv_cfg_t        cfg_in,
    input  fdiv_step_t       step,
    output fdiv_cfg_t        cfg_cur,
    output logic [ACC_W-1:0] acc_cur,
    output logic             mod_tick,
    output logic             gated_off
);
    typedef struct packed {
        logic             run;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [ACC_W-1:0] acc;
        fdiv_cfg_t        cfg;
        logic             tick;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic       boundary;

    always_comb begin
        st_d     = st_q;
        boundary = st_q.run && src_tick && (st_q.cnt == st_q.len - LEN_W'(1));
        if (!st_q.run) begin
            st_d.cnt = '0;
            st_d.len = LEN_W'(1);
            st_d.acc = '0;
        end else if (src_tick) begin
            if (boundary) begin
                st_d.cnt = '0;
                st_d.len = step.len;
                st_d.acc = step.acc;
                st_d.cfg = cfg_in;
            end else begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
        end
        st_d.tick = boundary;
        st_d.run  = run_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run  <= 1'b1;
            st_q.cnt  <= '0;
            st_q.len  <= LEN_W'(1);
            st_q.acc  <= '0;
            st_q.cfg  <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_cur   = st_q.cfg;
    assign acc_cur   = st_q.acc;
    assign mod_tick  = st_q.tick;
    assign gated_off = !st_q.run;

    logic [LEN_W-1:0] n_chk;
    assign n_chk = (st_q.cfg.div_int == '0) ? LEN_W'(1) : LEN_W'(st_q.cfg.div_int);

    // R9: counter always inside the current period
    p_cnt_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.len);

    // R9: a tick follows a sampled selected source tick
    p_tick_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mod_tick |-> $past(src_tick));

    // R3: accumulator stays below the denominator
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.num != '0 && st_q.cfg.den != '0 && st_q.cfg.num < st_q.cfg.den)
        |-> (st_q.acc < ACC_W'(st_q.cfg.den)));

    // R4: integer-only settings give length N (startup length 1 excepted)
    p_int_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cfg.num == '0 || st_q.cfg.den == '0) && st_q.len != LEN_W'(1))
        |-> (st_q.len == n_chk));

    // R6: over-unity fraction stretches every period
    p_full_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.den != '0 && st_q.cfg.num >= st_q.cfg.den && st_q.len != LEN_W'(1))
        |-> (st_q.len == n_chk + LEN_W'(1)));

    // R7: stored settings change only at a period end
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(boundary) |-> $stable(st_q.cfg));

    // R8: no tick after a gated cycle
    p_gate_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gated_off) |-> !mod_tick);
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
    import fdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic              xtal_tick,
    input  logic              rc_tick,
    output logic              mod_tick,
    output logic              gated_off
);
    fdiv_cfg_t        cfg_in;
    fdiv_cfg_t        cfg_cur;
    fdiv_step_t       step;
    logic [ACC_W-1:0] acc_cur;
    logic             src_tick;

    assign cfg_in.src_sel = src_sel;
    assign cfg_in.div_int = div_int;
    assign cfg_in.num     = frac_num;
    assign cfg_in.den     = frac_den;

    fdiv_src_mux u_mux (
        .src_ticks ({rc_tick, xtal_tick}),
        .sel       (cfg_cur.src_sel),
        .tick      (src_tick)
    );

    fdiv_frac_step u_step (
        .cur_cfg (cfg_cur),
        .new_cfg (cfg_in),
        .acc_in  (acc_cur),
        .nxt     (step)
    );

    fdiv_period_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .src_tick  (src_tick),
        .cfg_in    (cfg_in),
        .step      (step),
        .cfg_cur   (cfg_cur),
        .acc_cur   (acc_cur),
        .mod_tick  (mod_tick),
        .gated_off (gated_off)
    );
endmodule

// File: tb/sim_frac_tick_div.sv
module sim_frac_tick_div;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic       src_sel;
    logic [7:0] div_int;
    logic [5:0] frac_num;
    logic [5:0] frac_den;
    logic       xtal_tick;
    logic       rc_tick;
    logic       mod_tick;
    logic       gated_off;

    always #4 clk = ~clk;

    frac_tick_div u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .div_int(div_int), .frac_num(frac_num), .frac_den(frac_den),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .mod_tick(mod_tick), .gated_off(gated_off)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    ticks_seen = 0;
    int    p_xt = 100;
    int    p_rc = 100;
    int    p_off = 0;
    bit    rand_gate = 0;
    string tag = "R1";

    int m_run, m_cnt, m_len, m_acc, m_tick;
    int m_sel, m_div, m_num, m_den;

    function automatic void plan_period(input int c_sel, c_div, c_num, c_den,
                                        input int n_sel, n_div, n_num, n_den,
                                        input int acc, output int len, output int acc_o);
        int n, base, sum;
        n    = (n_div == 0) ? 1 : n_div;
        base = (c_sel == n_sel && c_div == n_div && c_num == n_num && c_den == n_den) ? acc : 0;
        sum  = base + n_num;
        len  = n;
        acc_o = 0;
        if (n_num != 0 && n_den != 0 && n_num < n_den) begin
            if (sum >= n_den) begin
                len = n + 1;
                acc_o = sum - n_den;
            end else begin
                acc_o = sum;
            end
        end else if (n_num != 0 && n_den != 0) begin
            len = n + 1;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1; m_cnt = 0; m_len = 1; m_acc = 0; m_tick = 0;
            m_sel = 0; m_div = 0; m_num = 0; m_den = 0;
        end else begin
            int stick, bnd, nl, na;
            stick  = (m_sel != 0) ? int'(rc_tick) : int'(xtal_tick);
            bnd    = (m_run != 0 && stick != 0 && m_cnt == m_len - 1) ? 1 : 0;
            m_tick = bnd;
            if (m_run == 0) begin
                m_cnt = 0; m_len = 1; m_acc = 0;
            end else if (stick != 0) begin
                if (bnd != 0) begin
                    plan_period(m_sel, m_div, m_num, m_den,
                                int'(src_sel), int'(div_int), int'(frac_num), int'(frac_den),
                                m_acc, nl, na);
                    m_len = nl; m_acc = na; m_cnt = 0;
                    m_sel = int'(src_sel); m_div = int'(div_int);
                    m_num = int'(frac_num); m_den = int'(frac_den);
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_run = int'(run_en);
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, "mod_tick", int'(mod_tick), m_tick);
            check(tag, "gated_off", int'(gated_off), (m_run == 0) ? 1 : 0);
            ticks_seen += int'(mod_tick);
            xtal_tick = ($urandom_range(99) < p_xt);
            rc_tick   = ($urandom_range(99) < p_rc);
            if (rand_gate) run_en = ($urandom_range(99) >= p_off);
        end
    endtask

    task automatic count_window(input string req, input int n, input int exp);
        ticks_seen = 0;
        step(n);
        check(req, "tick count", ticks_seen, exp);
    endtask

    task automatic set_cfg(input int s, input int d, input int a, input int b);
        src_sel = s[0]; div_int = d[7:0]; frac_num = a[5:0]; frac_den = b[5:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; run_en = 1'b1; xtal_tick = 1'b0; rc_tick = 1'b0;
        set_cfg(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R1", "mod_tick in reset", int'(mod_tick), 0);
        check("R1", "gated_off in reset", int'(gated_off), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mod_tick after reset", int'(mod_tick), 0);
        check("R1", "gated_off after reset", int'(gated_off), 0);

        tag = "R5"; p_xt = 100; p_rc = 0;
        set_cfg(0, 0, 0, 0);
        step(20);
        count_window("R5", 50, 50);

        tag = "R4";
        set_cfg(0, 4, 0, 5);
        step(20);
        count_window("R4", 400, 100);
        set_cfg(0, 4, 3, 0);
        step(20);
        count_window("R4", 400, 100);

        tag = "R3";
        set_cfg(0, 3, 1, 3);
        step(30);
        count_window("R3", 100, 30);
        set_cfg(0, 5, 2, 5);
        step(40);
        count_window("R3", 270, 50);

        tag = "R6";
        set_cfg(0, 2, 5, 3);
        step(20);
        count_window("R6", 300, 100);

        tag = "R2"; p_xt = 100; p_rc = 100;
        set_cfg(1, 2, 0, 0);
        step(20);
        p_rc = 0;
        count_window("R2", 50, 0);

        tag = "R7";
        set_cfg(0, 2, 0, 0);
        count_window("R7", 50, 0);
        p_rc = 100;
        step(20);
        tag = "R2"; p_rc = 0; p_xt = 100;
        count_window("R2", 60, 30);

        tag = "R7";
        set_cfg(0, 20, 0, 0);
        step(45);
        ticks_seen = 0;
        while (ticks_seen == 0) step(1);
        step(5);
        set_cfg(0, 2, 0, 0);
        count_window("R7", 14, 0);
        count_window("R7", 1, 1);

        tag = "R8";
        run_en = 1'b0;
        step(1);
        @(negedge clk);
        check("R8", "gated_off after run low", int'(gated_off), 1);
        count_window("R8", 50, 0);
        run_en = 1'b1;
        step(2);
        check("R8", "gated_off after resume", int'(gated_off), 0);
        count_window("R8", 40, 20);

        tag = "R9";
        for (int ph = 0; ph < 25; ph++) begin
            int d;
            d = ($urandom_range(3) == 0) ? int'($urandom_range(40)) : int'($urandom_range(7));
            set_cfg(int'($urandom_range(1)), d, int'($urandom_range(63)),
                    ($urandom_range(1) == 0) ? int'($urandom_range(7)) : int'($urandom_range(63)));
            p_xt = int'($urandom_range(30, 100));
            p_rc = int'($urandom_range(30, 100));
            rand_gate = (ph % 3 == 2);
            p_off = 5;
            step(300);
            set_cfg(int'($urandom_range(1)), int'($urandom_range(9)),
                    int'($urandom_range(15)), int'($urandom_range(15)));
            step(300);
            rand_gate = 0;
            run_en = 1'b1;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule